// File: doc/BRIEF.md
# Asynchronous Byte-Wide SRAM Strobe Controller

This block sits between a simple synchronous host port and an asynchronous static RAM of 2,097,152 bytes (21 address bits, 8 data bits). A host asks for one byte transfer at a time by raising a request with a write flag, an address and write data. The controller then runs the active-low chip-enable, write-enable and output-enable strobes. It keeps the address and write data on the memory side and tells the pad logic when to drive the shared data bus. It finishes with a one-clock done pulse, and for a read the captured byte comes back with that pulse.

Every analog minimum of the memory is a parameter given in nanoseconds. At elaboration each one is rounded up to whole cycles of `CLK_PERIOD_NS`. The intervals covered are access after address and after output-enable, write pulse width, data setup before the end of the pulse, data hold after it, write recovery and the full write cycle. Output-enable never goes low during a write. A new request is taken only once the recovery interval of the previous one has ended.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: While reset is high and right after it, `mem_ce_n`, `mem_we_n` and `mem_oe_n` are 1, and `mem_drv` and `done` are 0.
- R2: A read holds `mem_ce_n` and `mem_oe_n` at 0 with `mem_we_n` at 1 for ceil(max(access, output-enable access)/period) cycles. It samples `mem_din` on the last of those cycles and returns the byte on `rdata` together with `done`.
- R3: A write lowers `mem_ce_n` and `mem_we_n` on the same edge and keeps both low for ceil(max(pulse width, data setup)/period) cycles. `mem_oe_n` stays 1 whenever `mem_we_n` is 0.
- R4: `mem_drv` is 1 from the edge where `mem_we_n` falls until ceil(hold/period) cycles after it rises. `mem_dout` does not change while `mem_drv` is 1, and `mem_drv` is never 1 while `mem_oe_n` is 0.
- R5: `mem_addr` does not change while `mem_ce_n` is 0 or while `mem_drv` is 1.
- R6: After each transfer the strobes stay high for at least ceil(recovery/period) cycles before `mem_ce_n` falls again. A request raised while a transfer is in progress is dropped and changes no memory byte.
- R7: `done` is a one-cycle pulse. Counting the accepting edge as 1, it is high after edge access+recovery+1 for a read, and after edge pulse+write-recovery+1 for a write.
- R8: The write-recovery length is max(recovery, hold, full write cycle minus pulse) in cycles. Every interval is rounded up from nanoseconds to whole clock periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Transfer request, sampled only when idle |
| wr | input | 1 | 1 selects a write, 0 a read |
| addr | input | ADDR_W | Byte address |
| wdata | input | DATA_W | Byte to write |
| rdata | output | DATA_W | Byte captured by the last read |
| done | output | 1 | One-cycle completion pulse |
| mem_addr | output | ADDR_W | Memory address bus |
| mem_dout | output | DATA_W | Data toward the memory |
| mem_din | input | DATA_W | Data from the memory |
| mem_drv | output | 1 | Enables the pad driver for `mem_dout` |
| mem_ce_n | output | 1 | Active-low chip enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_oe_n | output | 1 | Active-low output enable |

## Verification
The bench's memory model returns a poison byte until a read has been active for the full access interval with a stable address. A read that samples too early therefore shows up as a data mismatch, not as a timing violation that nobody checks. Directed writes and reads at address zero and at the top address separate correct address decoding from truncated address paths. Seeded random mixes of reads and writes over a small address window make addresses collide, so a stored value that is wrong or dropped is read back and exposed. A write request injected in the middle of a read tells apart a controller that drops busy-time requests from one that queues them or corrupts memory.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2,
    ST_REC  = 2'd3
  } seq_st_e;

  // Round a nanosecond interval up to whole clock periods.
  function automatic int ns_to_cyc(input int ns, input int per);
    return (ns + per - 1) / per;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic [CNT_W-1:0] len,
  output logic [CNT_W-1:0] cnt,
  output logic             last
);

  // Elapsed-cycle counter for the current phase.
  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign last = (cnt == len - 1'b1);

endmodule

// File: rtl/sram_req_latch.sv
module sram_req_latch #(
  parameter int ADDR_W = 21,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              wr_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o,
  output logic              wr_o
);

  // Holds the accepted request for the whole transfer and beyond,
  // so the address and data stay put through hold and recovery.
  always_ff @(posedge clk) begin
    if (rst) begin
      addr_o <= '0;
      data_o <= '0;
      wr_o   <= 1'b0;
    end else if (load) begin
      addr_o <= addr_i;
      data_o <= data_i;
      wr_o   <= wr_i;
    end
  end

endmodule

// File: rtl/sram_strobe_ctrl.sv
module sram_strobe_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W        = 21,
  parameter int DATA_W        = 8,
  parameter int CLK_PERIOD_NS = 4,
  parameter int T_ACC_NS      = 70,
  parameter int T_OE_NS       = 35,
  parameter int T_WP_NS       = 55,
  parameter int T_WC_NS       = 70,
  parameter int T_DS_NS       = 30,
  parameter int T_DH_NS       = 10,
  parameter int T_WR_NS       = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              done,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dout,
  input  logic [DATA_W-1:0] mem_din,
  output logic              mem_drv,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic              mem_oe_n
);

  // Phase lengths in cycles (R8).
  localparam int RD_LEN   = imax(imax(ns_to_cyc(T_ACC_NS, CLK_PERIOD_NS),
                                      ns_to_cyc(T_OE_NS, CLK_PERIOD_NS)), 1);
  localparam int WP_LEN   = imax(imax(ns_to_cyc(T_WP_NS, CLK_PERIOD_NS),
                                      ns_to_cyc(T_DS_NS, CLK_PERIOD_NS)), 1);
  localparam int DH_LEN   = ns_to_cyc(T_DH_NS, CLK_PERIOD_NS);
  localparam int RREC_LEN = imax(ns_to_cyc(T_WR_NS, CLK_PERIOD_NS), 1);
  localparam int WREC_LEN = imax(imax(RREC_LEN, DH_LEN),
                                 ns_to_cyc(T_WC_NS, CLK_PERIOD_NS) - WP_LEN);
  localparam int MAX_LEN  = imax(imax(RD_LEN, WP_LEN), imax(RREC_LEN, WREC_LEN));
  localparam int CNT_W    = $clog2(MAX_LEN + 1) + 1;

  seq_st_e          st;
  logic             accept;
  logic             restart;
  logic [CNT_W-1:0] ph_len;
  logic [CNT_W-1:0] ph_cnt;
  logic             ph_last;
  logic             lat_wr;

  assign accept  = (st == ST_IDLE) && req;
  assign restart = accept || ((st != ST_IDLE) && ph_last);

  always_comb begin
    case (st)
      ST_RD:   ph_len = CNT_W'(RD_LEN);
      ST_WR:   ph_len = CNT_W'(WP_LEN);
      ST_REC:  ph_len = lat_wr ? CNT_W'(WREC_LEN) : CNT_W'(RREC_LEN);
      default: ph_len = CNT_W'(1);
    endcase
  end

  sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .restart (restart),
    .len     (ph_len),
    .cnt     (ph_cnt),
    .last    (ph_last)
  );

  sram_req_latch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_latch (
    .clk    (clk),
    .rst    (rst),
    .load   (accept),
    .addr_i (addr),
    .data_i (wdata),
    .wr_i   (wr),
    .addr_o (mem_addr),
    .data_o (mem_dout),
    .wr_o   (lat_wr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      mem_ce_n <= 1'b1;
      mem_we_n <= 1'b1;
      mem_oe_n <= 1'b1;
      mem_drv  <= 1'b0;
      done     <= 1'b0;
      rdata    <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (req) begin
            mem_ce_n <= 1'b0;
            if (wr) begin
              st       <= ST_WR;
              mem_we_n <= 1'b0;
              mem_drv  <= 1'b1;
            end else begin
              st       <= ST_RD;
              mem_oe_n <= 1'b0;
            end
          end
        end
        ST_RD: begin
          if (ph_last) begin
            rdata    <= mem_din;
            mem_ce_n <= 1'b1;
            mem_oe_n <= 1'b1;
            st       <= ST_REC;
          end
        end
        ST_WR: begin
          if (ph_last) begin
            mem_we_n <= 1'b1;
            mem_ce_n <= 1'b1;
            mem_drv  <= (DH_LEN > 0);
            st       <= ST_REC;
          end
        end
        ST_REC: begin
          if (mem_drv && (int'(ph_cnt) + 1 >= DH_LEN)) begin
            mem_drv <= 1'b0;
          end
          if (ph_last) begin
            done    <= 1'b1;
            mem_drv <= 1'b0;
            st      <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sram_strobe_ctrl_chk.sv
module sram_strobe_ctrl_chk #(
  parameter int ADDR_W = 21,
  parameter int DATA_W = 8,
  parameter int WP_MIN = 14
) (
  input logic              clk,
  input logic              rst,
  input logic              done,
  input logic              mem_ce_n,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic              mem_drv,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_dout
);

  logic [15:0] wp_run;

  always_ff @(posedge clk) begin
    if (rst) begin
      wp_run <= '0;
    end else if (!mem_we_n) begin
      wp_run <= wp_run + 1'b1;
    end else begin
      wp_run <= '0;
    end
  end

  AST_OE_OFF_IN_WRITE: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> mem_oe_n); // R3

  AST_WE_INSIDE_CE: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> !mem_ce_n); // R3

  AST_WP_MIN: assert property (@(posedge clk) disable iff (rst)
    (mem_we_n && $past(!mem_we_n)) |-> (int'(wp_run) >= WP_MIN)); // R3

  AST_DRV_NO_OE: assert property (@(posedge clk) disable iff (rst)
    mem_drv |-> mem_oe_n); // R4

  AST_DOUT_STABLE: assert property (@(posedge clk) disable iff (rst)
    (mem_drv && $past(mem_drv)) |-> $stable(mem_dout)); // R4

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
    ((!mem_ce_n || mem_drv) && $past(!mem_ce_n || mem_drv)) |-> $stable(mem_addr)); // R5

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> (mem_ce_n && !mem_drv)); // R6

  AST_DONE_ONE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R7

endmodule

bind sram_strobe_ctrl sram_strobe_ctrl_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .WP_MIN ((T_WP_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .done     (done),
  .mem_ce_n (mem_ce_n),
  .mem_we_n (mem_we_n),
  .mem_oe_n (mem_oe_n),
  .mem_drv  (mem_drv),
  .mem_addr (mem_addr),
  .mem_dout (mem_dout)
);

// File: tb/sram_strobe_ctrl_bench.sv
module sram_strobe_ctrl_bench;

  localparam int AW  = 21;
  localparam int DW  = 8;
  localparam int PER = 4;

  function automatic int up(input int ns);
    return (ns + PER - 1) / PER;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int ACC_C = up(70);
  localparam int OE_C  = up(35);
  localparam int WP_C  = up(55);
  localparam int WC_C  = up(70);
  localparam int DS_C  = up(30);
  localparam int DH_C  = up(10);
  localparam int WR_C  = up(15);

  function automatic int exp_lat(input bit w);
    int p;
    p = mx(WP_C, DS_C);
    if (w) return p + mx(mx(WR_C, DH_C), WC_C - p) + 1;
    return mx(ACC_C, OE_C) + WR_C + 1;
  endfunction

  logic          clk = 1'b0;
  logic          rst;
  logic          req, wr;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata, rdata, mem_dout, mem_din;
  logic          done, mem_drv, mem_ce_n, mem_we_n, mem_oe_n;
  logic [AW-1:0] mem_addr;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic [7:0] model_mem [int];
  logic [7:0] ref_mem [int];

  always #2 clk = ~clk;

  sram_strobe_ctrl u_sram_strobe_ctrl (
    .clk(clk), .rst(rst), .req(req), .wr(wr), .addr(addr), .wdata(wdata),
    .rdata(rdata), .done(done), .mem_addr(mem_addr), .mem_dout(mem_dout),
    .mem_din(mem_din), .mem_drv(mem_drv), .mem_ce_n(mem_ce_n),
    .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n)
  );

  task automatic chk(input bit ok, input string rq, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  function automatic logic [7:0] rd_ref(input int a);
    return ref_mem.exists(a) ? ref_mem[a] : 8'h00;
  endfunction

  // Behavioural memory, evaluated between clock edges.
  logic          p_ce, p_we, p_drv, pend;
  logic [AW-1:0] p_addr, c_addr;
  logic [DW-1:0] p_dout;
  int we_lo, stab, post, hi, acc;

  always @(negedge clk) begin
    if (rst) begin
      p_ce = 1; p_we = 1; p_drv = 0; pend = 0;
      we_lo = 0; stab = 0; post = 0; hi = 100; acc = 0;
      mem_din = 8'hEE;
    end else begin
      if (!mem_we_n && !mem_oe_n) chk(0, "R3", "oe low in write", 0, 1);
      if (mem_drv && !mem_oe_n) chk(0, "R4", "drive with oe", 0, 1);
      if (p_ce && !mem_ce_n) chk(hi >= WR_C, "R6", "recovery cycles", hi, WR_C);
      hi = mem_ce_n ? hi + 1 : 0;
      if (!p_we && mem_we_n) begin
        chk(we_lo >= WP_C, "R3", "write pulse cycles", we_lo, WP_C);
        chk(stab >= DS_C, "R4", "data setup cycles", stab, DS_C);
        model_mem[int'(p_addr)] = p_dout;
        c_addr = p_addr;
        pend = 1;
        post = 0;
      end
      we_lo = !mem_we_n ? we_lo + 1 : 0;
      if (mem_drv && p_drv && mem_dout == p_dout) stab++;
      else stab = mem_drv ? 1 : 0;
      if (pend && mem_drv) post++;
      if (pend && p_drv && !mem_drv) begin
        chk(post >= DH_C, "R4", "data hold cycles", post, DH_C);
        chk(p_addr == c_addr, "R5", "address through hold", int'(p_addr), int'(c_addr));
        pend = 0;
      end
      if (!mem_ce_n && !mem_oe_n && mem_we_n && (acc == 0 || mem_addr == p_addr)) acc++;
      else acc = 0;
      if (acc >= mx(ACC_C, OE_C))
        mem_din = model_mem.exists(int'(mem_addr)) ? model_mem[int'(mem_addr)] : 8'h00;
      else
        mem_din = 8'hEE;
      p_ce = mem_ce_n; p_we = mem_we_n; p_drv = mem_drv;
      p_addr = mem_addr; p_dout = mem_dout;
    end
  end

  task automatic access(input bit w, input logic [AW-1:0] a, input logic [7:0] d,
                        output logic [7:0] q, output int lat);
    @(negedge clk);
    req = 1; wr = w; addr = a; wdata = d; lat = 0;
    @(posedge clk); lat = 1;
    @(negedge clk); req = 0; wr = 0;
    while (!done && lat < 400) begin
      @(posedge clk); lat++;
      @(negedge clk);
    end
    q = rdata;
    @(negedge clk);
    chk(done == 0, "R7", "done width", done, 0);
    if (w) ref_mem[int'(a)] = d;
  endtask

  task automatic do_wr(input logic [AW-1:0] a, input logic [7:0] d, input bit lat_chk);
    logic [7:0] q; int lat;
    access(1, a, d, q, lat);
    if (lat_chk) chk(lat == exp_lat(1), "R8", "write latency R7", lat, exp_lat(1));
  endtask

  task automatic do_rd(input logic [AW-1:0] a, input bit lat_chk);
    logic [7:0] q; int lat;
    access(0, a, 8'h00, q, lat);
    chk(q == rd_ref(int'(a)), "R2", "read data", q, rd_ref(int'(a)));
    if (lat_chk) chk(lat == exp_lat(0), "R7", "read latency R8", lat, exp_lat(0));
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1; req = 0; wr = 0; addr = '0; wdata = '0;
    void'($urandom(32'd7021));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk({mem_ce_n, mem_we_n, mem_oe_n} == 3'b111, "R1", "strobes in reset",
        {mem_ce_n, mem_we_n, mem_oe_n}, 3'b111);
    chk(!mem_drv && !done, "R1", "drive/done in reset", {mem_drv, done}, 0);
    rst = 0;
    @(negedge clk);
    chk({mem_ce_n, mem_we_n, mem_oe_n, mem_drv} == 4'b1110, "R1", "idle after reset",
        {mem_ce_n, mem_we_n, mem_oe_n, mem_drv}, 4'b1110);

    // Directed corners: lowest and highest address.
    do_wr(21'h000000, 8'hA5, 1);
    do_wr(21'h1FFFFF, 8'h5A, 1);
    do_rd(21'h000000, 1);
    do_rd(21'h1FFFFF, 1);
    do_rd(21'h000123, 0);

    // Random mix over a small window so addresses collide.
    for (int i = 0; i < 60; i++) begin
      logic [AW-1:0] a;
      logic [7:0]    d;
      a = (i % 13 == 0) ? 21'h1FFFFF : AW'($urandom % 16);
      d = 8'($urandom);
      if (d == 8'hEE) d = 8'h11;
      if ($urandom % 2) do_wr(a, d, 0);
      else do_rd(a, i < 4);
    end

    // R6: a write request raised during a read is dropped.
    begin
      logic [7:0] q; int lat;
      @(negedge clk);
      req = 1; wr = 0; addr = 21'h000003;
      @(negedge clk); req = 0;
      repeat (5) @(negedge clk);
      req = 1; wr = 1; addr = 21'h000007; wdata = 8'h3C;
      @(negedge clk); req = 0; wr = 0;
      lat = 0;
      while (!done && lat < 400) begin @(negedge clk); lat++; end
      chk(rdata == rd_ref(3), "R2", "read under busy request", rdata, rd_ref(3));
      @(negedge clk);
      access(0, 21'h000007, 8'h00, q, lat);
      chk(q == rd_ref(7), "R6", "busy request dropped", q, rd_ref(7));
    end

    repeat (5) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule